// File: doc/BRIEF.md
# Serial-Programmed Crosspoint Control Register Block

This block is the digital control side of a 12-input, 9-output video routing matrix. A two-wire serial host (I2C-compatible, write-only) programs it. The block oversamples the serial clock and data lines with its own system clock and detects bus start and stop conditions. It accepts a transaction only when the first byte matches its device address, which a strap pin selects. Each accepted transaction carries a register address byte and then one or more data bytes. Every byte it accepts is acknowledged by pulling the data line low.

Nine output registers each hold an enable bit, a two-bit gain code and a five-bit input selector. Two further registers hold one clamp/bias choice per input. From these registers the block drives per-output enable, gain and select lines, a one-hot route matrix and the clamp/bias select lines.

The byte handler is a single state machine with eight states:

- `ST_IDLE`: waits for a start condition.
- `ST_DEV`: shifts in the device byte.
- `ST_DEV_ACK`: drives the acknowledge for the device byte.
- `ST_REG`: shifts in the register address.
- `ST_REG_ACK`: acknowledges the register address.
- `ST_DATA`: shifts in a data byte.
- `ST_DATA_ACK`: acknowledges the data byte and commits the write.
- `ST_SKIP`: holds the bus released after an address mismatch.

The transitions are:

- A stop condition from any state goes to `ST_IDLE`. A start or repeated start from any state goes to `ST_DEV`.
- On the SCL falling edge after the eighth bit, `ST_DEV` goes to `ST_DEV_ACK` on a match and to `ST_SKIP` otherwise.
- On the SCL falling edge after the eighth bit, `ST_REG` goes to `ST_REG_ACK` and `ST_DATA` goes to `ST_DATA_ACK`.
- On the SCL falling edge that ends the acknowledge bit, `ST_DEV_ACK` goes to `ST_REG`, `ST_REG_ACK` goes to `ST_DATA`, and `ST_DATA_ACK` goes back to `ST_DATA`.

Top module: `xpt_ctrl_i2c`

## Requirements
- R1: The accepted device byte is 0x06 when `addr_strap_i` is 0 and 0x86 when it is 1. Bit 0 of that byte is the direction bit, and only the value 0 (write) is acknowledged. Any other first byte is not acknowledged.
- R2: Registers 0x01 to 0x09 belong to outputs 1 to 9, with output k at vector index k-1. In each of them bit 7 drives `out_en_o`, bits 6:5 drive the two-bit slice of `out_gain_o`, and bits 4:0 drive the five-bit slice of `out_sel_o`. Outputs change only when a data byte is committed.
- R3: Route bit `route_o[o*12+i]` is 1 only when output o is enabled and its selector equals i+1. Selector 0 and selectors 13 to 31 give no route, a disabled output routes nothing, and several outputs may pick the same input.
- R4: Register 0x1D bits 7:0 set `clamp_sel_o[7:0]`, and register 0x1E bits 3:0 set `clamp_sel_o[11:8]`. The upper bits of 0x1E have no visible effect. A value of 1 means clamp and 0 means bias.
- R5: Data written to any register address other than 0x01 to 0x09, 0x1D or 0x1E is acknowledged and changes no output.
- R6: After reset every output is 0 and `sda_pull_o` is 0.
- R7: When several data bytes follow in one transaction, each one goes to the next register address, with the address wrapping within 8 bits.
- R8: A repeated start restarts device-address matching, both after a mismatch and in the middle of an accepted transaction.
- R9: `sda_pull_o` is asserted only during acknowledge bits of an accepted transaction, and it changes only while SCL is low. After a device-address mismatch the block acknowledges nothing until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_strap_i | input | 1 | Device address select strap |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 = pull data line low (acknowledge) |
| out_en_o | output | 9 | Per-output enable |
| out_gain_o | output | 18 | Per-output gain code, 2 bits each |
| out_sel_o | output | 45 | Per-output input selector, 5 bits each |
| route_o | output | 108 | Route matrix, bit o*12+i |
| clamp_sel_o | output | 12 | Per-input clamp (1) / bias (0) |

## Verification
The assertions check on every cycle that each route row is at most one-hot and empty whenever its output is disabled. They also check that the acknowledge drive only changes while SCL is low, and that outputs hold still unless a byte is committed, including commits to undefined addresses. Only the bench's transaction scenarios can show the things that depend on whole byte sequences. These are device-address matching for both strap settings and the direction bit, the exact bit-to-field mapping of each register, auto-increment across several registers, and recovery through a repeated start. Randomised transactions are compared against a register-level model kept in the bench.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int          REG_AW     = 8;
    localparam int          GAIN_W     = 2;
    localparam int          SEL_W      = 5;
    localparam logic [7:0]  OUT_BASE   = 8'h01;
    localparam logic [7:0]  CLAMP_BASE = 8'h1D;
    localparam logic [7:0]  DEV_BYTE   = 8'h06;
    localparam int          EN_BIT     = 7;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_REG,
        ST_REG_ACK, ST_DATA, ST_DATA_ACK, ST_SKIP
    } xfer_st_t;
endpackage

// File: rtl/xpt_line_sync.sv
module xpt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p,
    output logic sda_bit
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_d, sda_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    always_comb begin
        sda_bit  = sda_q[STAGES-1];
        scl_rise = scl_q[STAGES-1] & ~scl_d;
        scl_fall = ~scl_q[STAGES-1] & scl_d;
        start_p  = scl_q[STAGES-1] & scl_d & sda_d & ~sda_q[STAGES-1];
        stop_p   = scl_q[STAGES-1] & scl_d & ~sda_d & sda_q[STAGES-1];
    end
endmodule

// File: rtl/xpt_xfer_fsm.sv
module xpt_xfer_fsm
    import xpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              sda_bit,
    input  logic [7:0]        dev_byte,
    output logic              sda_pull_o,
    output logic              wr_stb,
    output logic [REG_AW-1:0] wr_addr,
    output logic [7:0]        wr_data
);
    xfer_st_t          st, st_nx;
    logic [3:0]        bit_cnt;
    logic [7:0]        shreg;
    logic [REG_AW-1:0] ptr;
    logic              byte_done, rx_st, ack_st;

    always_comb begin
        rx_st     = (st == ST_DEV) || (st == ST_REG) || (st == ST_DATA);
        ack_st    = (st == ST_DEV_ACK) || (st == ST_REG_ACK) || (st == ST_DATA_ACK);
        byte_done = scl_fall && (bit_cnt == 4'd8);
        st_nx     = st;
        if (stop_p)       st_nx = ST_IDLE;
        else if (start_p) st_nx = ST_DEV;
        else begin
            unique case (st)
                ST_IDLE:     st_nx = ST_IDLE;
                ST_DEV:      if (byte_done) st_nx = (shreg == dev_byte) ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:  if (scl_fall) st_nx = ST_REG;
                ST_REG:      if (byte_done) st_nx = ST_REG_ACK;
                ST_REG_ACK:  if (scl_fall) st_nx = ST_DATA;
                ST_DATA:     if (byte_done) st_nx = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) st_nx = ST_DATA;
                ST_SKIP:     st_nx = ST_SKIP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            shreg   <= '0;
            ptr     <= '0;
        end else begin
            st <= st_nx;
            if (start_p)
                bit_cnt <= '0;
            else if (scl_rise && rx_st && bit_cnt != 4'd8) begin
                shreg   <= {shreg[6:0], sda_bit};
                bit_cnt <= bit_cnt + 4'd1;
            end else if (scl_fall && ack_st)
                bit_cnt <= '0;
            if (st == ST_REG && byte_done && !stop_p && !start_p)
                ptr <= shreg;
            else if (wr_stb)
                ptr <= ptr + 1'b1;
        end
    end

    always_comb begin
        sda_pull_o = ack_st;
        wr_stb     = (st == ST_DATA) && byte_done && !stop_p && !start_p;
        wr_addr    = ptr;
        wr_data    = shreg;
    end
endmodule

// File: rtl/xpt_regfile.sv
module xpt_regfile
    import xpt_pkg::*;
#(
    parameter int N_OUT = 9,
    parameter int N_IN  = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_stb,
    input  logic [REG_AW-1:0]       wr_addr,
    input  logic [7:0]              wr_data,
    output logic [N_OUT-1:0]        out_en_o,
    output logic [GAIN_W*N_OUT-1:0] out_gain_o,
    output logic [SEL_W*N_OUT-1:0]  out_sel_o,
    output logic [N_OUT*N_IN-1:0]   route_o,
    output logic [N_IN-1:0]         clamp_sel_o
);
    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic [7:0] ctl;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ctl <= '0;
            else if (wr_stb && wr_addr == REG_AW'(OUT_BASE + o))
                ctl <= wr_data;
        end
        assign out_en_o[o]                   = ctl[EN_BIT];
        assign out_gain_o[o*GAIN_W +: GAIN_W] = ctl[6:5];
        assign out_sel_o[o*SEL_W +: SEL_W]    = ctl[SEL_W-1:0];
        for (genvar i = 0; i < N_IN; i++) begin : g_in
            assign route_o[o*N_IN+i] = ctl[EN_BIT] && (ctl[SEL_W-1:0] == SEL_W'(i+1));
        end
    end

    for (genvar i = 0; i < N_IN; i++) begin : g_clamp
        logic cbit;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cbit <= 1'b0;
            else if (wr_stb && wr_addr == REG_AW'(CLAMP_BASE + i/8))
                cbit <= wr_data[i%8];
        end
        assign clamp_sel_o[i] = cbit;
    end
endmodule

// File: rtl/xpt_ctrl_i2c.sv
module xpt_ctrl_i2c
    import xpt_pkg::*;
#(
    parameter int N_OUT       = 9,
    parameter int N_IN        = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    addr_strap_i,
    input  logic                    scl_i,
    input  logic                    sda_i,
    output logic                    sda_pull_o,
    output logic [N_OUT-1:0]        out_en_o,
    output logic [GAIN_W*N_OUT-1:0] out_gain_o,
    output logic [SEL_W*N_OUT-1:0]  out_sel_o,
    output logic [N_OUT*N_IN-1:0]   route_o,
    output logic [N_IN-1:0]         clamp_sel_o
);
    logic              scl_rise, scl_fall, start_p, stop_p, sda_bit;
    logic              wr_stb;
    logic [REG_AW-1:0] wr_addr;
    logic [7:0]        wr_data;
    logic [7:0]        dev_byte;

    assign dev_byte = {addr_strap_i, DEV_BYTE[6:0]};

    xpt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p), .sda_bit(sda_bit)
    );

    xpt_xfer_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p), .sda_bit(sda_bit),
        .dev_byte(dev_byte), .sda_pull_o(sda_pull_o),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    xpt_regfile #(.N_OUT(N_OUT), .N_IN(N_IN)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
        .wr_data(wr_data), .out_en_o(out_en_o), .out_gain_o(out_gain_o),
        .out_sel_o(out_sel_o), .route_o(route_o), .clamp_sel_o(clamp_sel_o)
    );
endmodule

// File: rtl/xpt_ctrl_chk.sv
module xpt_ctrl_chk
    import xpt_pkg::*;
#(
    parameter int N_OUT = 9,
    parameter int N_IN  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    scl_i,
    input logic                    sda_pull_o,
    input logic [N_OUT-1:0]        out_en_o,
    input logic [GAIN_W*N_OUT-1:0] out_gain_o,
    input logic [SEL_W*N_OUT-1:0]  out_sel_o,
    input logic [N_OUT*N_IN-1:0]   route_o,
    input logic [N_IN-1:0]         clamp_sel_o,
    input logic                    wr_stb,
    input logic [REG_AW-1:0]       wr_addr
);
    localparam int N_CLAMP = (N_IN + 7) / 8;
    logic addr_known;
    assign addr_known = (wr_addr >= OUT_BASE && wr_addr < REG_AW'(OUT_BASE + N_OUT)) ||
                        (wr_addr >= CLAMP_BASE && wr_addr < REG_AW'(CLAMP_BASE + N_CLAMP));

    for (genvar o = 0; o < N_OUT; o++) begin : g_row
        assert_row_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(route_o[o*N_IN +: N_IN]));
        assert_off_no_route_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !out_en_o[o] |-> (route_o[o*N_IN +: N_IN] == '0));
    end

    assert_pull_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_pull_o) || $fell(sda_pull_o)) |-> !scl_i);

    assert_hold_no_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> ($stable(out_en_o) && $stable(out_gain_o) && $stable(out_sel_o)
                     && $stable(clamp_sel_o)));

    assert_undef_no_effect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !addr_known) |=> ($stable(out_en_o) && $stable(out_gain_o)
                     && $stable(out_sel_o) && $stable(clamp_sel_o)));
endmodule

bind xpt_ctrl_i2c xpt_ctrl_chk #(.N_OUT(N_OUT), .N_IN(N_IN)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o),
    .out_en_o(out_en_o), .out_gain_o(out_gain_o), .out_sel_o(out_sel_o),
    .route_o(route_o), .clamp_sel_o(clamp_sel_o),
    .wr_stb(wr_stb), .wr_addr(wr_addr)
);

// File: tb/sim_xpt_ctrl_i2c.sv
`timescale 1ns/1ps
module sim_xpt_ctrl_i2c;
    localparam int NO = 9, NI = 12, Q = 8;

    logic clk = 1'b0, rst_n = 1'b0, strap = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic sda_bus, sda_pull;
    logic [NO-1:0]    en;
    logic [2*NO-1:0]  gain;
    logic [5*NO-1:0]  sel;
    logic [NO*NI-1:0] route;
    logic [NI-1:0]    clamp;

    int n_tests = 0, n_fail = 0;
    logic [7:0] m_out [NO];
    logic [7:0] m_cl  [2];

    always #10 clk = ~clk;
    assign sda_bus = m_sda & ~sda_pull;

    xpt_ctrl_i2c u0 (
        .clk(clk), .rst_n(rst_n), .addr_strap_i(strap), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .out_en_o(en), .out_gain_o(gain), .out_sel_o(sel),
        .route_o(route), .clamp_sel_o(clamp)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wq(input int n); repeat (n) @(negedge clk); endtask

    task automatic i2c_start;
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
    endtask
    task automatic i2c_stop;
        m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(Q);
    endtask
    task automatic i2c_byte(input logic [7:0] b, output bit ack);
        for (int k = 7; k >= 0; k--) begin
            m_sda = b[k]; wq(Q); m_scl = 1'b1; wq(Q); m_scl = 1'b0;
        end
        m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q / 2);
        ack = !sda_bus;
        wq(Q - Q / 2); m_scl = 1'b0;
    endtask

    task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
        if (a >= 8'h01 && a <= 8'h09) m_out[a - 8'h01] = d;
        else if (a == 8'h1D) m_cl[0] = d;
        else if (a == 8'h1E) m_cl[1] = d;
    endtask

    // full write transaction; expect_ack chooses acknowledge expectations
    task automatic txn(input logic [7:0] dev, input logic [7:0] ra, input int n,
                       input logic [31:0] dat, input bit exp_ack, input string req);
        bit a;
        logic [7:0] p;
        i2c_start;
        i2c_byte(dev, a); chk(a == exp_ack, req, 128'(a), 128'(exp_ack));
        i2c_byte(ra, a);  chk(a == exp_ack, req, 128'(a), 128'(exp_ack));
        p = ra;
        for (int k = 0; k < n; k++) begin
            i2c_byte(dat[8*k +: 8], a); chk(a == exp_ack, req, 128'(a), 128'(exp_ack));
            if (exp_ack) model_wr(p, dat[8*k +: 8]);
            p = p + 8'd1;
        end
        i2c_stop;
        wq(4);
    endtask

    task automatic check_outs(input string req);
        logic [NO-1:0]    e_en;
        logic [2*NO-1:0]  e_g;
        logic [5*NO-1:0]  e_s;
        logic [NO*NI-1:0] e_r;
        logic [NI-1:0]    e_c;
        for (int o = 0; o < NO; o++) begin
            e_en[o] = m_out[o][7];
            e_g[2*o +: 2] = m_out[o][6:5];
            e_s[5*o +: 5] = m_out[o][4:0];
            for (int i = 0; i < NI; i++)
                e_r[o*NI+i] = m_out[o][7] && (int'(m_out[o][4:0]) == i + 1);
        end
        e_c = {m_cl[1][3:0], m_cl[0]};
        chk(en == e_en,     {req, " R2 en"},    128'(en), 128'(e_en));
        chk(gain == e_g,    {req, " R2 gain"},  128'(gain), 128'(e_g));
        chk(sel == e_s,     {req, " R2 sel"},   128'(sel), 128'(e_s));
        chk(route == e_r,   {req, " R3 route"}, 128'(route), 128'(e_r));
        chk(clamp == e_c,   {req, " R4 clamp"}, 128'(clamp), 128'(e_c));
    endtask

    function automatic logic [7:0] dev_ok(input logic s); return {s, 7'h06}; endfunction

    initial begin
        #4_000_000;
        n_fail++; n_tests++;
        $display("FAIL watchdog R6 act=%h exp=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        bit a;
        void'($urandom(32'd4242));
        foreach (m_out[k]) m_out[k] = '0;
        m_cl[0] = '0; m_cl[1] = '0;
        wq(5); rst_n = 1'b1; wq(5);

        // R6 reset state
        chk(sda_pull == 1'b0, "R6 pull", 128'(sda_pull), 0);
        check_outs("R6 reset");

        // R2 R3 basic output writes; selector 13 and disabled output give no route
        txn(dev_ok(0), 8'h01, 1, 32'h000000E3, 1, "R1 ack");
        txn(dev_ok(0), 8'h02, 1, 32'h0000008D, 1, "R1 ack");
        txn(dev_ok(0), 8'h03, 1, 32'h00000045, 1, "R1 ack");
        txn(dev_ok(0), 8'h09, 1, 32'h00000083, 1, "R1 ack");
        check_outs("R3 sel13/off/shared");
        chk(route[0*NI+2] && route[8*NI+2], "R3 shared input", 128'(route), 0);

        // R4 clamp registers, upper bits of second register invisible
        txn(dev_ok(0), 8'h1D, 2, 32'h0000F6A5, 1, "R4 ack");
        check_outs("R4 clamp");
        chk(clamp == 12'h6A5, "R4 clamp value", 128'(clamp), 128'(12'h6A5));

        // R5 undefined addresses
        txn(dev_ok(0), 8'h00, 1, 32'h000000FF, 1, "R5 ack");
        txn(dev_ok(0), 8'h20, 1, 32'h000000FF, 1, "R5 ack");
        txn(dev_ok(0), 8'h0A, 1, 32'h000000FF, 1, "R5 ack");
        check_outs("R5 undefined");

        // R7 auto-increment across three registers and wrap 0xFF->0x00->0x01
        txn(dev_ok(0), 8'h04, 3, 32'h00A1C2E7, 1, "R7 ack");
        check_outs("R7 incr");
        txn(dev_ok(0), 8'hFF, 3, 32'h0081FFFF, 1, "R7 ack");
        check_outs("R7 wrap");
        chk(en[0] && sel[4:0] == 5'd1, "R7 wrap to 0x01", 128'(sel[4:0]), 1);

        // R1 R9 wrong strap address and read bit: no acknowledge, no change
        txn(dev_ok(1), 8'h05, 1, 32'h000000FF, 0, "R9 mismatch");
        txn(8'h07, 8'h05, 1, 32'h000000FF, 0, "R1 read bit");
        check_outs("R9 no change");

        // R8 repeated start after mismatch, and mid-transaction
        i2c_start; i2c_byte(8'h44, a); chk(!a, "R8 mismatch", 128'(a), 0);
        i2c_start; i2c_byte(dev_ok(0), a); chk(a, "R8 rematch", 128'(a), 1);
        i2c_byte(8'h06, a);
        i2c_start; i2c_byte(dev_ok(0), a); chk(a, "R8 restart", 128'(a), 1);
        i2c_byte(8'h07, a); i2c_byte(8'h8C, a); chk(a, "R8 data ack", 128'(a), 1);
        model_wr(8'h07, 8'h8C);
        i2c_stop; wq(4);
        check_outs("R8 restart");

        // R1 strap high
        strap = 1'b1; wq(4);
        txn(dev_ok(0), 8'h06, 1, 32'h000000FF, 0, "R1 strap-hi old addr");
        txn(dev_ok(1), 8'h06, 1, 32'h000000AB, 1, "R1 strap-hi new addr");
        check_outs("R1 strap-hi");
        strap = 1'b0; wq(4);

        // random transactions against the model
        for (int t = 0; t < 60; t++) begin
            logic [7:0] ra, dv;
            int n;
            bit good;
            ra = ($urandom % 4 == 0) ? 8'($urandom) :
                 (($urandom % 3 == 0) ? 8'(8'h1D + $urandom % 2) : 8'(1 + $urandom % 9));
            n = 1 + int'($urandom % 3);
            good = ($urandom % 10) != 0;
            dv = good ? dev_ok(0) : 8'(($urandom % 2) ? 8'h86 : 8'h07);
            txn(dv, ra, n, $urandom, good, "R7 random");
            check_outs("R2 random");
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule